// File: doc/BRIEF.md
# Fuse Byte Read Controller

This block lets software fetch single bytes from a one-time-programmable fuse array through one 32-bit control word. Software writes the word with the top bit clear and a byte address in the middle field. The block then starts an access to the array, holds the top bit at 0 while the array works, and sets the top bit again once the fetched byte sits in the low field. Software polls that bit and treats a bit that never returns to 1 as a timeout. The flag therefore never comes back before the byte is valid.

A second, narrow register picks the fuse bank. The array model answers after a latency that depends on the address. It returns a fixed pattern computed from bank and address, and returns 0xFF for addresses past the end of the array.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset the control word reads 0x8000_0000 (flag set, address 0, byte 0) and the bank register reads 0.
- R2: A control write (`reg_sel`=0) with bit 31 = 0 while the flag is 1 starts a read. From the next cycle the word reads flag 0, address field [17:8] = wdata[17:8], byte field [7:0] = 0x00.
- R3: The flag (bit 31) returns to 1 exactly BASE_LAT + addr[1:0] cycles after the clock edge that accepted the starting write, and never earlier.
- R4: When the flag returns, bits [7:0] hold the fuse byte ((addr mod 256) + (addr div 256)·17) mod 256, XOR-ed with (bank·0x5B) mod 256, for addresses below ARRAY_BYTES.
- R5: An address at or above ARRAY_BYTES (768 by default) returns 0xFF in every bank.
- R6: Control writes accepted while the flag is 0 are ignored. This includes a write that lands on the very edge where the result arrives: address, byte and completion timing stay those of the running read.
- R7: A control write with bit 31 = 1 while idle starts nothing and leaves the control word unchanged.
- R8: A write with `reg_sel`=1 loads the bank register from wdata[BANK_W-1:0] at any time. A read uses the bank held when its start was accepted, so a bank change during an access affects only later reads.
- R9: All control-word bits outside 31, [17:8] and [7:0] read 0. A finished result stays unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the bank register |
| reg_wdata | input | 32 | Write data |
| ctrl_rdata | output | 32 | Current control word: flag, address field, byte field |
| bank_rdata | output | BANK_W | Current bank register |

## Verification
The risky overlap is a new control write arriving on the same edge as the array's answer. At that moment the flag is still 0, so the write must be dropped while the result is stored. The bench provokes this on alternate addresses of a full-array sweep. It drives a write with a different address in the cycle just before the computed completion edge. Half a cycle after that edge it expects the flag set, the original address and the byte of the original address. A bank write issued in the middle of an access is judged the same way: the result must still come from the old bank.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    localparam int unsigned CTRL_W    = 32;
    localparam int unsigned FLAG_BIT  = 31;
    localparam int unsigned ADDR_LSB  = 8;
    localparam int unsigned BYTE_W    = 8;
    localparam logic [7:0]  EMPTY_BYTE = 8'hFF;

    // Content pattern of the fuse array model for one bank and address.
    function automatic logic [7:0] fuse_byte(input logic [7:0] bank, input logic [15:0] addr);
        logic [7:0] lo;
        logic [7:0] hi;
        logic [7:0] mix;
        logic [7:0] salt;
        lo   = addr[7:0];
        hi   = addr[15:8];
        mix  = hi * 8'd17;
        salt = bank * 8'h5B;
        return (lo + mix) ^ salt;
    endfunction

endpackage

// File: rtl/fuse_array_model.sv
module fuse_array_model
    import fuse_pkg::*;
#(
    parameter int unsigned ADDR_W      = 10,
    parameter int unsigned ARRAY_BYTES = 768,
    parameter int unsigned BASE_LAT    = 3,
    parameter int unsigned BANK_W      = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BANK_W-1:0] req_bank,
    output logic              busy,
    output logic              rsp_valid,
    output logic [BYTE_W-1:0] rsp_data
);

    localparam int unsigned MAX_LAT = BASE_LAT + 3;
    localparam int unsigned CNT_W   = $clog2(MAX_LAT + 1);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [BANK_W-1:0] bank;
    } arr_state_t;

    arr_state_t st_d, st_q;
    logic [CNT_W-1:0] lat;

    always_comb begin
        st_d = st_q;
        lat  = CNT_W'(BASE_LAT) + CNT_W'(req_addr[1:0]);
        if (req) begin
            st_d.busy = 1'b1;
            st_d.cnt  = lat;
            st_d.addr = req_addr;
            st_d.bank = req_bank;
        end else if (st_q.busy) begin
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.busy;
    assign rsp_valid = st_q.busy && (st_q.cnt == CNT_W'(1));
    assign rsp_data  = (32'(st_q.addr) >= ARRAY_BYTES) ? EMPTY_BYTE
                     : fuse_byte(8'(st_q.bank), 16'(st_q.addr));

    // R2
    req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> !st_q.busy);

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.cnt >= CNT_W'(1) && st_q.cnt <= CNT_W'(MAX_LAT)));

endmodule

// File: rtl/fuse_ctrl_reg.sv
module fuse_ctrl_reg
    import fuse_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [CTRL_W-1:0] reg_wdata,
    input  logic              rsp_valid,
    input  logic [BYTE_W-1:0] rsp_data,
    output logic              start,
    output logic [ADDR_W-1:0] start_addr,
    output logic [BANK_W-1:0] bank,
    output logic [CTRL_W-1:0] ctrl_word
);

    localparam int unsigned PAD_W = CTRL_W - 1 - ADDR_LSB - ADDR_W;

    typedef struct packed {
        logic              flag;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
        logic [BANK_W-1:0] bank;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign start_addr   = reg_wdata[ADDR_LSB +: ADDR_W];

    always_comb begin
        st_d  = st_q;
        start = reg_wr && !reg_sel && !reg_wdata[FLAG_BIT] && st_q.flag;
        if (reg_wr && reg_sel) begin
            st_d.bank = reg_wdata[BANK_W-1:0];
        end
        if (start) begin
            st_d.flag = 1'b0;
            st_d.addr = start_addr;
            st_d.data = '0;
        end else if (rsp_valid) begin
            st_d.flag = 1'b1;
            st_d.data = rsp_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.flag <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank      = st_q.bank;
    assign ctrl_word = {st_q.flag, {PAD_W{1'b0}}, st_q.addr, st_q.data};

    // R3
    flag_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(rsp_valid));

    // R6
    pend_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && !st_q.flag) |=> $stable(st_q.addr));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !start) |=> ($stable(st_q.data) && $stable(st_q.addr)));

endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
    import fuse_pkg::*;
#(
    parameter int unsigned ADDR_W      = 10,
    parameter int unsigned ARRAY_BYTES = 768,
    parameter int unsigned BASE_LAT    = 3,
    parameter int unsigned BANK_W      = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       ctrl_rdata,
    output logic [BANK_W-1:0] bank_rdata
);

    logic              start;
    logic [ADDR_W-1:0] start_addr;
    logic [BANK_W-1:0] bank;
    logic              busy;
    logic              rsp_valid;
    logic [BYTE_W-1:0] rsp_data;

    fuse_ctrl_reg #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W)
    ) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .start      (start),
        .start_addr (start_addr),
        .bank       (bank),
        .ctrl_word  (ctrl_rdata)
    );

    fuse_array_model #(
        .ADDR_W      (ADDR_W),
        .ARRAY_BYTES (ARRAY_BYTES),
        .BASE_LAT    (BASE_LAT),
        .BANK_W      (BANK_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (start),
        .req_addr  (start_addr),
        .req_bank  (bank),
        .busy      (busy),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    assign bank_rdata = bank;

    // R6
    busy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ctrl_rdata[FLAG_BIT]);

endmodule

// File: tb/fuse_rd_ctrl_bench.sv
module fuse_rd_ctrl_bench;

    localparam int ADDR_W   = 10;
    localparam int ARR      = 768;
    localparam int BASE_LAT = 3;
    localparam int BANK_W   = 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic              reg_sel = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       ctrl_rdata;
    logic [BANK_W-1:0] bank_rdata;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    fuse_rd_ctrl #(
        .ADDR_W(ADDR_W), .ARRAY_BYTES(ARR), .BASE_LAT(BASE_LAT), .BANK_W(BANK_W)
    ) u_fuse_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .bank_rdata(bank_rdata)
    );

    function automatic logic [7:0] exp_byte(input int b, input int a);
        if (a >= ARR) return 8'hFF;
        return 8'((((a % 256) + (a / 256) * 17) % 256) ^ ((b * 91) % 256));
    endfunction

    function automatic logic [31:0] word(input bit f, input int a, input logic [7:0] d);
        return {f, 13'b0, 10'(a), d};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Runs one read; optionally collides a control write with the completion edge.
    task automatic run_read(input int b, input int a, input bit collide, input bit bank_flip);
        int lat;
        lat = BASE_LAT + (a % 4);
        wr(1'b0, word(1'b0, a, 8'h00));
        chk("R2 start", ctrl_rdata, word(1'b0, a, 8'h00));
        for (int m = 1; m < lat; m++) begin
            @(negedge clk);
            reg_wr = 1'b0;
            if (bank_flip && m == 1) begin
                reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 32'(1 - b);
            end
            if (m == lat - 1) begin
                chk("R3 not early", 32'(ctrl_rdata[31]), 32'd0);
                if (collide) begin
                    reg_wr = 1'b1; reg_sel = 1'b0;
                    reg_wdata = word(1'b0, a ^ 10'h3FF, 8'h00);
                end
            end
        end
        @(negedge clk);
        reg_wr = 1'b0;
        chk(a >= ARR ? "R5 empty" : (collide ? "R6 collide" : "R4 data"),
            ctrl_rdata, word(1'b1, a, exp_byte(b, a)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ctrl", ctrl_rdata, 32'h8000_0000);
        chk("R1 bank", 32'(bank_rdata), 32'd0);

        // R7: flag-set write does nothing
        wr(1'b0, 32'hFFFF_FFFF);
        repeat (BASE_LAT + 4) @(negedge clk);
        chk("R7 ignored", ctrl_rdata, 32'h8000_0000);

        // Sweep both banks across every address
        for (int b = 0; b < 2; b++) begin
            wr(1'b1, 32'(b));
            chk("R8 bank load", 32'(bank_rdata), 32'(b));
            for (int a = 0; a < (1 << ADDR_W); a++) begin
                run_read(b, a, (b == 1) && (a % 2 == 1), 1'b0);
            end
        end

        // R8: bank change during access affects only later reads
        wr(1'b1, 32'd0);
        run_read(0, 37, 1'b0, 1'b1);
        chk("R8 bank after flip", 32'(bank_rdata), 32'd1);
        run_read(1, 37, 1'b0, 1'b0);

        // R9: result holds, bank writes do not disturb it
        wr(1'b1, 32'd0);
        repeat (10) @(negedge clk);
        chk("R9 hold", ctrl_rdata, word(1'b1, 37, exp_byte(1, 37)));

        // R6: control write while pending does not retime the read
        wr(1'b0, word(1'b0, 5, 8'h00));
        wr(1'b0, word(1'b0, 700, 8'h00));
        repeat (BASE_LAT + 1 - 2) @(negedge clk);
        chk("R6 pending", ctrl_rdata, word(1'b1, 5, exp_byte(0, 5)));

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule